// File: doc/BRIEF.md
# Discrete-Time PLL Loop Filter

This block is a fixed-point digital model of a charge-pump loop filter. The analog filter is a resistor in series with a main capacitor, with a small smoothing capacitor in parallel. It was mapped to discrete time with the bilinear substitution. Each accepted sample is a signed charge increment. Each result is a signed control-voltage sample that drives an oscillator model or a digital oscillator tuning word.

The recursion has two parts in cascade. The first is a running sum (integrator) of the charge increments. The second is a first-order section with a pole at 1−k and a two-tap numerator m1 + m2·z⁻¹. Together they realise (m1 + m2·z⁻¹) / (1 + (k−2)·z⁻¹ + (1−k)·z⁻²). The three coefficients are signed fixed-point port values, normally held constant. They are worked out off-chip from the component values and the sample period. Internal state is wider than the output, and every stage clamps at its signed limits instead of wrapping.

Top module: `pll_loop_filter`

## Requirements
- R1: A synchronous reset, held for one or more clock edges, clears the integrator state, the section state, `v_out` and `out_valid` to zero.
- R2: On each clock edge with `in_valid` high, the integrator state becomes a_n = clamp(a_{n-1} + q_n) to the signed range of AW bits (default 24).
- R3: On the same edge, the section state becomes y_n = clamp(floor((m1·a_n + m2·a_{n-1} + y_{n-1}·2^F − k·y_{n-1}) / 2^F)) to YW signed bits (default 24). Here F = FRAC (default 14). The values k, m1 and m2 are two's-complement coefficients of CW bits (default 18) with F fractional bits, sampled on that edge.
- R4: `v_out` is y_n clamped to the signed range of OW bits (default 16). A large positive result gives 32767 and a large negative result gives −32768, never a wrapped value.
- R5: `out_valid` is high on exactly the cycles that follow a cycle with `in_valid` high, and `v_out` takes its new value on that same edge.
- R6: On cycles with `in_valid` low, `q_in` is ignored: the state, `v_out` and `out_valid` low are held.
- R7: From cleared state, a strobed zero sample gives `v_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking `q_in` as a new sample |
| q_in | input | QW | Signed charge increment |
| coef_k | input | CW | Pole coefficient k, signed with FRAC fractional bits |
| coef_m1 | input | CW | Current-sample tap m1, signed with FRAC fractional bits |
| coef_m2 | input | CW | Delayed-sample tap m2, signed with FRAC fractional bits |
| out_valid | output | 1 | High the cycle after an accepted sample |
| v_out | output | OW | Signed, clamped control-voltage sample |

## Verification
A result is due one clock edge after its strobe: `v_out` and `out_valid` change on the first rising edge at which `in_valid` is seen high. The bench drives each sample on a falling edge and compares on the next falling edge against a 64-bit integer model of the same recursion. On cycles without a strobe, the same falling-edge comparison checks that the output held its value and that `out_valid` stayed low. Impulse, step, clamping, back-to-back and seeded random sequences with gaps all use this single one-edge timing rule.

// File: rtl/pllf_pkg.sv
package pllf_pkg;

   // Overflow handling for every narrowing point in the datapath
   typedef enum logic {
      OVF_WRAP  = 1'b0,
      OVF_CLAMP = 1'b1
   } ovf_mode_e;

endpackage

// File: rtl/pllf_sat.sv
module pllf_sat #(
   parameter int                  IW   = 32,
   parameter int                  OW   = 16,
   parameter pllf_pkg::ovf_mode_e MODE = pllf_pkg::OVF_CLAMP
) (
   input  logic signed [IW-1:0] din,
   output logic signed [OW-1:0] dout
);

   generate
      if (IW <= OW) begin : g_widen
         assign dout = OW'(din);
      end else if (MODE == pllf_pkg::OVF_WRAP) begin : g_wrap
         assign dout = din[OW-1:0];
      end else begin : g_clamp
         localparam int EXT = IW - OW + 1;
         localparam logic signed [IW-1:0] HI = {{EXT{1'b0}}, {(OW-1){1'b1}}};
         localparam logic signed [IW-1:0] LO = {{EXT{1'b1}}, {(OW-1){1'b0}}};
         always_comb begin
            if (din > HI)      dout = HI[OW-1:0];
            else if (din < LO) dout = LO[OW-1:0];
            else               dout = din[OW-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/pllf_integrator.sv
module pllf_integrator #(
   parameter int                  QW   = 16,
   parameter int                  AW   = 24,
   parameter pllf_pkg::ovf_mode_e MODE = pllf_pkg::OVF_CLAMP
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic signed [QW-1:0] q,
   output logic signed [AW-1:0] acc_d,
   output logic signed [AW-1:0] acc_q
);

   localparam int SUMW = AW + 1;

   logic signed [SUMW-1:0] sum;

   assign sum = SUMW'(acc_q) + SUMW'(q);

   pllf_sat #(.IW(SUMW), .OW(AW), .MODE(MODE)) u_sat (
      .din  (sum),
      .dout (acc_d)
   );

   always_ff @(posedge clk) begin
      if (rst)     acc_q <= '0;
      else if (en) acc_q <= acc_d;
   end

endmodule

// File: rtl/pllf_section.sv
module pllf_section #(
   parameter int                  AW   = 24,
   parameter int                  CW   = 18,
   parameter int                  FRAC = 14,
   parameter int                  YW   = 24,
   parameter pllf_pkg::ovf_mode_e MODE = pllf_pkg::OVF_CLAMP
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic signed [AW-1:0] a_cur,
   input  logic signed [AW-1:0] a_old,
   input  logic signed [CW-1:0] k,
   input  logic signed [CW-1:0] m1,
   input  logic signed [CW-1:0] m2,
   output logic signed [YW-1:0] y_d,
   output logic signed [YW-1:0] y_q
);

   localparam int PW = (CW + AW > CW + YW) ? CW + AW : CW + YW;
   localparam int SW = ((PW > YW + FRAC) ? PW : YW + FRAC) + 3;

   logic signed [SW-1:0] p_cur;
   logic signed [SW-1:0] p_old;
   logic signed [SW-1:0] p_fb;
   logic signed [SW-1:0] p_keep;
   logic signed [SW-1:0] total;
   logic signed [SW-1:0] scaled;

   assign p_cur  = SW'(m1) * SW'(a_cur);
   assign p_old  = SW'(m2) * SW'(a_old);
   assign p_fb   = SW'(k)  * SW'(y_q);
   assign p_keep = SW'(y_q) <<< FRAC;
   assign total  = p_cur + p_old + p_keep - p_fb;
   assign scaled = total >>> FRAC;

   pllf_sat #(.IW(SW), .OW(YW), .MODE(MODE)) u_sat (
      .din  (scaled),
      .dout (y_d)
   );

   always_ff @(posedge clk) begin
      if (rst)     y_q <= '0;
      else if (en) y_q <= y_d;
   end

endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter #(
   parameter int                  QW   = 16,
   parameter int                  AW   = 24,
   parameter int                  CW   = 18,
   parameter int                  FRAC = 14,
   parameter int                  YW   = 24,
   parameter int                  OW   = 16,
   parameter pllf_pkg::ovf_mode_e MODE = pllf_pkg::OVF_CLAMP
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic signed [QW-1:0] q_in,
   input  logic signed [CW-1:0] coef_k,
   input  logic signed [CW-1:0] coef_m1,
   input  logic signed [CW-1:0] coef_m2,
   output logic                 out_valid,
   output logic signed [OW-1:0] v_out
);

   generate
      if (AW <= QW) begin : g_chk_aw
         $error("pll_loop_filter: AW must exceed QW");
      end
      if (YW < OW) begin : g_chk_yw
         $error("pll_loop_filter: YW must be at least OW");
      end
      if (FRAC < 1 || FRAC >= CW) begin : g_chk_frac
         $error("pll_loop_filter: FRAC must lie in 1..CW-1");
      end
   endgenerate

   logic signed [AW-1:0] acc_d;
   logic signed [AW-1:0] acc_q;
   logic signed [YW-1:0] y_d;
   logic signed [YW-1:0] y_q;
   logic signed [OW-1:0] v_d;

   // Stage 1: running sum of charge increments
   pllf_integrator #(.QW(QW), .AW(AW), .MODE(MODE)) u_int (
      .clk   (clk),
      .rst   (rst),
      .en    (in_valid),
      .q     (q_in),
      .acc_d (acc_d),
      .acc_q (acc_q)
   );

   // Stage 2: pole at 1-k, taps m1 on new sum and m2 on previous sum
   pllf_section #(.AW(AW), .CW(CW), .FRAC(FRAC), .YW(YW), .MODE(MODE)) u_sec (
      .clk   (clk),
      .rst   (rst),
      .en    (in_valid),
      .a_cur (acc_d),
      .a_old (acc_q),
      .k     (coef_k),
      .m1    (coef_m1),
      .m2    (coef_m2),
      .y_d   (y_d),
      .y_q   (y_q)
   );

   pllf_sat #(.IW(YW), .OW(OW), .MODE(MODE)) u_osat (
      .din  (y_d),
      .dout (v_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         v_out     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) v_out <= v_d;
      end
   end

endmodule

// File: rtl/pllf_loop_filter_chk.sv
module pllf_loop_filter_chk #(
   parameter int QW = 16,
   parameter int AW = 24,
   parameter int YW = 24,
   parameter int OW = 16
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic signed [QW-1:0] q_in,
   input logic                 out_valid,
   input logic signed [OW-1:0] v_out,
   input logic signed [AW-1:0] acc_q,
   input logic signed [YW-1:0] y_q
);

   localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};

   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (!out_valid && v_out == '0 && acc_q == '0 && y_q == '0));

   // R5
   a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   a_r5_valid_drops: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R6
   a_r6_output_holds: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(v_out));

   a_r6_state_holds: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(acc_q) && $stable(y_q)));

   // R2
   a_r2_sum_rises: assert property (@(posedge clk) disable iff (rst)
      (in_valid && q_in > 0 && acc_q != AMAX) |=> (acc_q > $past(acc_q)));

   // R7
   a_r7_zero_stays: assert property (@(posedge clk) disable iff (rst)
      (in_valid && q_in == '0 && acc_q == '0 && y_q == '0) |=> (v_out == '0));

endmodule

bind pll_loop_filter pllf_loop_filter_chk #(
   .QW (QW),
   .AW (AW),
   .YW (YW),
   .OW (OW)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .q_in      (q_in),
   .out_valid (out_valid),
   .v_out     (v_out),
   .acc_q     (acc_q),
   .y_q       (y_q)
);

// File: tb/pll_loop_filter_tb.sv
module pll_loop_filter_tb;

   localparam int QW = 16, AW = 24, CW = 18, FRAC = 14, YW = 24, OW = 16;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic signed [QW-1:0] q_in = '0;
   logic signed [CW-1:0] coef_k = '0;
   logic signed [CW-1:0] coef_m1 = '0;
   logic signed [CW-1:0] coef_m2 = '0;
   logic                 out_valid;
   logic signed [OW-1:0] v_out;

   int n_checks = 0;
   int n_fail   = 0;

   longint ra, ry, ck, cm1, cm2, last_exp;
   bit     prev_v;

   always #4 clk = ~clk;

   pll_loop_filter #(.QW(QW), .AW(AW), .CW(CW), .FRAC(FRAC), .YW(YW), .OW(OW)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .q_in      (q_in),
      .coef_k    (coef_k),
      .coef_m1   (coef_m1),
      .coef_m2   (coef_m2),
      .out_valid (out_valid),
      .v_out     (v_out)
   );

   function automatic longint satw(longint v, int w);
      longint hi, lo;
      hi = (longint'(1) <<< (w - 1)) - 1;
      lo = -(longint'(1) <<< (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic longint model(longint q);
      longint aold;
      aold = ra;
      ra   = satw(ra + q, AW);
      ry   = satw((cm1 * ra + cm2 * aold + (ry <<< FRAC) - ck * ry) >>> FRAC, YW);
      return satw(ry, OW);
   endfunction

   task automatic check(string req, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_coef(longint k, longint m1, longint m2);
      ck = k; cm1 = m1; cm2 = m2;
      coef_k = CW'(k); coef_m1 = CW'(m1); coef_m2 = CW'(m2);
   endtask

   // One cycle: check the result of the previous edge, then drive this one
   task automatic step(bit v, longint q, string req);
      @(negedge clk);
      if (prev_v) begin
         check(req, longint'(v_out), last_exp);
         check("R5 out_valid high", longint'(out_valid), 1);
      end else begin
         check("R6 hold", longint'(v_out), last_exp);
         check("R5 out_valid low", longint'(out_valid), 0);
      end
      in_valid = v;
      q_in     = QW'(q);
      if (v) last_exp = model(q);
      prev_v = v;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1 v_out", longint'(v_out), 0);
      check("R1 out_valid", longint'(out_valid), 0);
      rst = 1'b0;
      ra = 0; ry = 0; last_exp = 0; prev_v = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R5 watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20517));
      ra = 0; ry = 0; last_exp = 0; prev_v = 0;
      set_coef(819, 19661, -18022);
      do_reset();

      // R7: zero sample from cleared state
      step(1, 0, "R7 zero in");
      step(0, 0, "R7");
      check("R7 zero out", longint'(v_out), 0);

      // R3: impulse response
      step(1, 100, "R3 impulse");
      for (int i = 0; i < 20; i++) step(1, 0, "R3 impulse tail");
      step(0, 1234, "R6 ignored");
      step(0, -999, "R6 ignored");

      // R3: step response, back to back
      do_reset();
      for (int i = 0; i < 30; i++) step(1, 5, "R3 step");
      step(0, 0, "R3");

      // R4: positive and negative clamping
      do_reset();
      for (int i = 0; i < 300; i++) step(1, 32767, "R4 pos");
      step(0, 0, "R4");
      check("R4 clamp high", longint'(v_out), 32767);
      do_reset();
      for (int i = 0; i < 300; i++) step(1, -32768, "R4 neg");
      step(0, 0, "R4");
      check("R4 clamp low", longint'(v_out), -32768);

      // R2: integrator clamps; with pole at zero, out = floor(a / 2^14)
      do_reset();
      set_coef(16384, 1, 0);
      for (int i = 0; i < 300; i++) step(1, 32767, "R2 sum");
      step(0, 0, "R2");
      check("R2 sum clamp high", longint'(v_out), 511);
      do_reset();
      for (int i = 0; i < 300; i++) step(1, -32768, "R2 sum");
      step(0, 0, "R2");
      check("R2 sum clamp low", longint'(v_out), -512);

      // R3/R6: seeded random coefficients, samples and gaps
      for (int r = 0; r < 4; r++) begin
         do_reset();
         set_coef(longint'($urandom_range(0, 16384)),
                  longint'($urandom_range(0, 80000)) - 40000,
                  longint'($urandom_range(0, 80000)) - 40000);
         for (int i = 0; i < 400; i++) begin
            step(($urandom_range(0, 3) != 0),
                 longint'($urandom_range(0, 2000)) - 1000, "R3 random");
         end
         step(0, 0, "R3");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule